// File: doc/BRIEF.md
# Grouped Maskable Interrupt Aggregator

This block gathers 160 level-sensitive interrupt sources, arranged as five groups of 32 lines. Each group has a fixed set of implemented bits. A source is active when its pending bit is 1 and its mask bit is 0. For every group the block drives one summary request onto an 8-bit CPU interrupt-line vector, with group g on line g+2. A separate top-priority line, line 7, passes straight through from an input.

Software sees each group through a four-word window on a simple single-cycle register bus. The window holds a read-only pending word, a polarity word that only the last group implements, and a read/write mask word.

A dispatch view tells a handler which source to serve. Line 7 wins over everything. Otherwise the highest-numbered active group is chosen, and inside it the highest-numbered active bit. The result is reported as the flat number group×32 + bit.

The first 14 lines of the last group can be set active-high or active-low. Their status is latched, and it is cleared only by masking the line.

Top module: `grp_irq_agg`

## Requirements
- R1: Implemented bits per group are 0x0000EFFF, 0x00001FFF, 0x00000007, 0x0003FFFF and 0xFFFFFFFF for groups 0 to 4. Other bits read 0 in pending and mask, and never raise a request.
- R2: Address bits [4:2] select the group and bits [1:0] select the word: 0 = pending (read-only), 1 = polarity, 2 = mask. Read data appears one cycle after `reg_rd_i` and is 0 in any other cycle. Reads of an absent group, or of the polarity word of groups 0 to 3, return 0. Writes take effect at the next clock edge.
- R3: A mask bit of 1 blocks its source and a mask bit of 0 enables it. After reset every mask word equals its group's implemented bits.
- R4: `cpu_lines_o[g+2]` is high exactly when group g has an active source. `cpu_lines_o[1:0]` are always 0. A group whose mask equals its implemented bits drives its line low.
- R5: `cpu_irq7_i` appears on `cpu_lines_o[7]` one cycle later. While that line is high, dispatch reports `disp_hi_o`=1 and `disp_num_o`=0.
- R6: When line 7 is low, dispatch selects the highest-numbered group with an active source, then the highest-numbered active bit in that group, and reports `disp_num_o` = group×32 + bit.
- R7: `disp_valid_o` is 0 exactly when line 7 is low and no source in any group is active.
- R8: In group 4, polarity bits 13:0 select the active level of source bits 0 to 13: 1 = active high, 0 = active low. Polarity resets to 0x3FFF. Every other source is active high.
- R9: Group 4 bits 0 to 13 latch: once active, the pending bit stays 1 after the source goes away. Every other pending bit follows its source level one cycle later.
- R10: A mask write that sets one of group 4 bits 0 to 13 to 1 clears that bit's latched status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 160 | Source levels, bit g*32+b is group g bit b |
| cpu_irq7_i | input | 1 | Top-priority CPU line input |
| reg_addr_i | input | 5 | Word address {group, word} |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read |
| cpu_lines_o | output | 8 | CPU interrupt lines, group g on bit g+2, bit 7 top line |
| disp_valid_o | output | 1 | Some request is present |
| disp_hi_o | output | 1 | Line 7 is the request served |
| disp_num_o | output | 8 | Flat number of the selected source |

## Verification
All results arrive one clock edge after their cause:
- A source level, polarity value, mask word or line 7 input is registered, and its effect shows on the CPU lines and the dispatch view after the next edge.
- Read data is registered and valid in the cycle after the strobe.
- A polarity change needs one edge to load the register and a second edge before a source is seen through it.

The driver applies each stimulus just after a rising edge and queues the results due after the following edge. The monitor compares the queue at the falling edge that comes next, where no register is changing.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int NGRP     = 5;
    localparam int GW       = 32;
    localparam int NPOL     = 14;
    localparam int POL_GRP  = 4;
    localparam int LINE_OFS = 2;
    localparam int AW       = 5;

    typedef enum logic [1:0] {
        W_PEND = 2'd0,
        W_POL  = 2'd1,
        W_MASK = 2'd2,
        W_RSVD = 2'd3
    } word_e;

    function automatic logic [GW-1:0] grp_valid(input int g);
        case (g)
            0:       return 32'h0000_EFFF;
            1:       return 32'h0000_1FFF;
            2:       return 32'h0000_0007;
            3:       return 32'h0003_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/grp_irq_bank.sv
module grp_irq_bank #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    VALID = '1,
    parameter int              NPOL  = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         wr_mask_i,
    input  logic         wr_pol_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] act_o,
    output logic         req_o
);
    localparam logic [W-1:0] POLM = (NPOL == 0) ? '0 : W'((64'd1 << NPOL) - 64'd1);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] mask;
        logic [W-1:0] pol;
    } bank_t;

    bank_t s_d, s_q;
    logic [W-1:0] lvl, clr;

    always_comb begin
        s_d = s_q;
        // polarity applies only inside POLM; elsewhere the level is taken as is
        lvl = src_i ~^ (s_q.pol | ~POLM);
        clr = wr_mask_i ? (wdata_i & POLM) : '0;
        s_d.pend = ((lvl & ~POLM) | ((s_q.pend | lvl) & POLM & ~clr)) & VALID;
        if (wr_mask_i) s_d.mask = wdata_i & VALID;
        if (wr_pol_i)  s_d.pol  = wdata_i & POLM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend <= '0;
            s_q.mask <= VALID;
            s_q.pol  <= POLM;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign mask_o = s_q.mask;
    assign pol_o  = s_q.pol;
    assign act_o  = s_q.pend & ~s_q.mask;
    assign req_o  = |act_o;
endmodule

// File: rtl/grp_irq_pick.sv
module grp_irq_pick #(
    parameter int NG = 5,
    parameter int W  = 32,
    parameter int NW = $clog2(NG * W)
) (
    input  logic [NG*W-1:0] act_i,
    input  logic            top_i,
    output logic            valid_o,
    output logic            hi_o,
    output logic [NW-1:0]   num_o
);
    localparam int GB = (NG > 1) ? $clog2(NG) : 1;
    localparam int BB = $clog2(W);

    logic          any;
    logic [GB-1:0] grp;
    logic [BB-1:0] bit_idx;
    logic [W-1:0]  row;

    always_comb begin
        any = 1'b0;
        grp = '0;
        // ascending scan, last hit wins: highest-numbered group
        for (int g = 0; g < NG; g++) begin
            if (|act_i[g*W +: W]) begin
                any = 1'b1;
                grp = GB'(g);
            end
        end
        row = act_i[grp*W +: W];
        bit_idx = '0;
        for (int b = 0; b < W; b++) begin
            if (row[b]) bit_idx = BB'(b);
        end
        valid_o = top_i | any;
        hi_o    = top_i;
        num_o   = (top_i || !any) ? '0 : NW'(int'(grp) * W + int'(bit_idx));
    end
endmodule

// File: rtl/grp_irq_agg.sv
module grp_irq_agg
    import grp_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NGRP*GW-1:0]   src_i,
    input  logic                 cpu_irq7_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [GW-1:0]        reg_wdata_i,
    output logic [GW-1:0]        reg_rdata_o,
    output logic [7:0]           cpu_lines_o,
    output logic                 disp_valid_o,
    output logic                 disp_hi_o,
    output logic [7:0]           disp_num_o
);
    localparam int NW = $clog2(NGRP * GW);

    typedef struct packed {
        logic          top;
        logic [GW-1:0] rdata;
    } top_t;

    top_t s_d, s_q;

    logic [NGRP*GW-1:0] pend_all, mask_all, pol_all, act_all;
    logic [NGRP-1:0]    req_w;
    logic [2:0]         a_grp;
    word_e              a_word;
    logic [NW-1:0]      num_w;

    assign a_grp  = reg_addr_i[AW-1:2];
    assign a_word = word_e'(reg_addr_i[1:0]);

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        logic hit;
        assign hit = (int'(a_grp) == g);
        grp_irq_bank #(
            .W     (GW),
            .VALID (grp_valid(g)),
            .NPOL  ((g == POL_GRP) ? NPOL : 0)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[g*GW +: GW]),
            .wr_mask_i (reg_wr_i && hit && a_word == W_MASK),
            .wr_pol_i  (reg_wr_i && hit && a_word == W_POL),
            .wdata_i   (reg_wdata_i),
            .pend_o    (pend_all[g*GW +: GW]),
            .mask_o    (mask_all[g*GW +: GW]),
            .pol_o     (pol_all[g*GW +: GW]),
            .act_o     (act_all[g*GW +: GW]),
            .req_o     (req_w[g])
        );
    end

    grp_irq_pick #(.NG(NGRP), .W(GW), .NW(NW)) u_pick (
        .act_i   (act_all),
        .top_i   (s_q.top),
        .valid_o (disp_valid_o),
        .hi_o    (disp_hi_o),
        .num_o   (num_w)
    );

    always_comb begin
        s_d       = s_q;
        s_d.top   = cpu_irq7_i;
        s_d.rdata = '0;
        if (reg_rd_i && int'(a_grp) < NGRP) begin
            case (a_word)
                W_PEND:  s_d.rdata = pend_all[a_grp*GW +: GW];
                W_POL:   s_d.rdata = pol_all[a_grp*GW +: GW];
                W_MASK:  s_d.rdata = mask_all[a_grp*GW +: GW];
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cpu_lines_o = '0;
        cpu_lines_o[7] = s_q.top;
        for (int g = 0; g < NGRP; g++) cpu_lines_o[g+LINE_OFS] = req_w[g];
    end

    assign reg_rdata_o = s_q.rdata;
    assign disp_num_o  = 8'(num_w);
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk
    import grp_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_irq7_i,
    input logic                 reg_rd_i,
    input logic [GW-1:0]        reg_rdata_o,
    input logic [7:0]           cpu_lines_o,
    input logic                 disp_valid_o,
    input logic                 disp_hi_o,
    input logic [7:0]           disp_num_o,
    input logic [NGRP*GW-1:0]   pend_all,
    input logic [NGRP*GW-1:0]   mask_all
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        p_unimpl_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend_all[g*GW +: GW] | mask_all[g*GW +: GW]) & ~grp_valid(g)) == '0);
        p_all_masked_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_all[g*GW +: GW] == grp_valid(g)) |-> !cpu_lines_o[g+LINE_OFS]);
    end

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> (reg_rdata_o == '0));

    p_low_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_lines_o[1:0] == 2'b00);

    p_top_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq7_i |=> (cpu_lines_o[7] && disp_hi_o && disp_num_o == 8'd0));

    p_group_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && !disp_hi_o) |-> cpu_lines_o[int'(disp_num_o[7:5]) + LINE_OFS]);

    p_valid_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o == (|cpu_lines_o[7:LINE_OFS]));
endmodule

bind grp_irq_agg grp_irq_chk u_chk (.*);

// File: tb/grp_irq_agg_tb.sv
module grp_irq_agg_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [159:0] src_i = '0;
    logic         cpu_irq7_i = 1'b0;
    logic [4:0]   reg_addr_i = '0;
    logic         reg_wr_i = 1'b0;
    logic         reg_rd_i = 1'b0;
    logic [31:0]  reg_wdata_i = '0;
    logic [31:0]  reg_rdata_o;
    logic [7:0]   cpu_lines_o;
    logic         disp_valid_o;
    logic         disp_hi_o;
    logic [7:0]   disp_num_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    grp_irq_agg u_dut (.*);

    function automatic logic [31:0] dexp(input logic v, input logic h, input int n);
        return {22'd0, v, h, n[7:0]};
    endfunction

    task automatic push(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int grp, input int word, input logic [31:0] d);
        reg_addr_i = 5'((grp << 2) | word); reg_wdata_i = d; reg_wr_i = 1'b1;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input int grp, input int word, input logic [31:0] exp, input string tag);
        reg_addr_i = 5'((grp << 2) | word); reg_rd_i = 1'b1;
        step();
        reg_rd_i = 1'b0;
        push(0, exp, tag);
    endtask

    // monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = q.pop_front();
            case (it.sel)
                0:       got = reg_rdata_o;
                1:       got = {24'd0, cpu_lines_o};
                default: got = {22'd0, disp_valid_o, disp_hi_o, disp_num_o};
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        push(1, 32'h0, "R4 reset lines");
        push(2, dexp(0, 0, 0), "R7 reset dispatch");
        rd(0, 2, 32'h0000_EFFF, "R3 reset mask g0");
        rd(4, 1, 32'h0000_3FFF, "R8 reset polarity g4");

        // group 2: all sources high, only 3 bits implemented, still masked
        src_i[95:64] = '1;
        step();
        rd(2, 0, 32'h7, "R1 pending g2");
        push(1, 32'h0, "R4 masked group quiet");

        wr(2, 2, 32'h0);
        push(1, 32'h10, "R4 line of g2");
        push(2, dexp(1, 0, 66), "R6 g2 bit2");

        // group 0: bit 12 unimplemented, bit 3 real
        wr(0, 2, 32'h0);
        src_i[12] = 1'b1;
        step();
        rd(0, 0, 32'h0, "R1 unimpl bit g0");
        push(1, 32'h10, "R1 no request from unimpl");
        src_i[3] = 1'b1;
        step();
        push(1, 32'h14, "R4 two lines");
        push(2, dexp(1, 0, 66), "R6 higher group wins");

        wr(2, 2, 32'hFFFF_FFFF);
        push(1, 32'h04, "R4 all masked drops line");
        push(2, dexp(1, 0, 3), "R6 g0 bit3");
        rd(2, 2, 32'h7, "R3 mask readback g2");
        src_i[11] = 1'b1;
        step();
        push(2, dexp(1, 0, 11), "R6 highest bit");

        cpu_irq7_i = 1'b1;
        step();
        push(1, 32'h84, "R5 line7");
        push(2, dexp(1, 1, 0), "R5 line7 first");
        cpu_irq7_i = 1'b0;
        step();
        push(1, 32'h04, "R5 line7 gone");

        src_i = '0;
        step();
        push(1, 32'h0, "R7 lines idle");
        push(2, dexp(0, 0, 0), "R7 no request");

        // group 4 polarity
        wr(4, 2, 32'h0);
        wr(4, 1, 32'h0000_3FFE);
        step();
        push(1, 32'h40, "R8 active-low bit0");
        push(2, dexp(1, 0, 128), "R8 dispatch bit0");
        wr(4, 1, 32'h0000_3FFF);
        step();
        push(2, dexp(1, 0, 128), "R9 bit0 stays latched");

        src_i[133] = 1'b1;
        step();
        src_i[133] = 1'b0;
        step();
        push(2, dexp(1, 0, 133), "R9 bit5 latched");
        rd(4, 0, 32'h21, "R9 pending g4");

        src_i[148] = 1'b1;
        step();
        push(2, dexp(1, 0, 148), "R9 bit20 level");
        src_i[148] = 1'b0;
        step();
        push(2, dexp(1, 0, 133), "R9 bit20 not sticky");

        wr(4, 2, 32'h20);
        push(2, dexp(1, 0, 128), "R10 mask bit5");
        wr(4, 2, 32'h0);
        rd(4, 0, 32'h1, "R10 bit5 cleared");

        rd(6, 0, 32'h0, "R2 absent group");
        rd(0, 1, 32'h0, "R2 no polarity g0");
        step();
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule